// File: doc/BRIEF.md
# Receive Descriptor Ring Poll Controller

This block decides when the receive side of an Ethernet controller walks its ring of buffer descriptors in memory. Software hands buffers to the hardware by marking descriptors as empty. It then writes a one-bit command register to arm polling. The value written does not matter: the write itself arms the controller.

While polling is armed and the global Ethernet enable is high, the controller does the following:
- It fetches the descriptor at the ring pointer.
- If the descriptor's empty flag is set, it offers that buffer to the frame-receive datapath. When the frame completes, it writes the status word back with the empty flag cleared, then moves to the next descriptor.
- If the empty flag is clear, the ring is exhausted. The controller disarms itself and sleeps until software writes the command register again.

Dropping the enable disarms the controller at once and rewinds the ring pointer to the programmed base address.

Top module: `rx_ring_poller`

## Requirements
- R1: A write strobe on `cmd_wr` while `eth_en` is high sets the active bit on the next clock edge, whatever value `cmd_wdata` carries.
- R2: `cmd_rdata` shows the active bit at bit 24 and zero in every other bit, so an armed controller reads 32'h0100_0000 and a disarmed one reads 0.
- R3: Descriptor fetches (`desc_req`) occur only while the active bit and `eth_en` are both set. When the active bit is clear, the controller issues no fetch, offer or write-back.
- R4: A fetched status word with bit 15 (empty) clear clears the active bit. No further fetch occurs until the next command write.
- R5: Reset clears the active bit. A low `eth_en` clears it on the next edge, and this overrides a command write in the same cycle.
- R6: A fetched descriptor with bit 15 set is offered on `rx_buf_valid` with its address on `rx_buf_addr`. After `rx_done`, the controller writes the fetched status with bit 15 cleared back to that same address.
- R7: After a write-back, the ring pointer returns to `ring_base` if status bit 13 (wrap) was set. Otherwise it advances by 8 bytes.
- R8: A command write in the same cycle as a not-empty fetch keeps the active bit set, so polling resumes and re-fetches that descriptor.
- R9: A low `eth_en` rewinds the ring pointer to `ring_base`, so the first fetch after re-enabling and re-arming is at the base address.
- R10: At most one of fetch request, buffer offer and write-back request is active in any cycle, so only one descriptor fetch is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eth_en | input | 1 | Global Ethernet enable |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command write data (ignored) |
| cmd_rdata | output | 32 | Command register readback, active bit at bit 24 |
| desc_req | output | 1 | Descriptor fetch request, held until acknowledged |
| desc_addr | output | AW | Address of the descriptor being fetched |
| desc_ack | input | 1 | Fetch acknowledge; `desc_status` is valid with it |
| desc_status | input | SW | Fetched status word (bit 15 empty, bit 13 wrap) |
| rx_buf_valid | output | 1 | Buffer offered to the receive datapath |
| rx_buf_addr | output | AW | Address of the offered descriptor |
| rx_done | input | 1 | Receive datapath finished the frame |
| wb_req | output | 1 | Status write-back request, held until acknowledged |
| wb_addr | output | AW | Write-back descriptor address |
| wb_data | output | SW | Status to write back, empty flag cleared |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
The bench builds the block with a 16-bit address and a 16-bit status word. Its ring has eight descriptors at base 0x0100, with a wrap flag placed on the fourth entry, so the return to base is reached after only a few frames. A bench-side memory model answers fetches and absorbs write-backs. It can stall the receive datapath, which lets the enable be dropped while a buffer is offered part way around the ring. It can also assert a command write in exactly the cycle a not-empty descriptor is acknowledged, which reaches the set-versus-clear collision.

// File: rtl/rxp_pkg.sv
// Shared types for the receive descriptor ring poll controller.
package rxp_pkg;
    // Poll sequencer states: wait, fetch a descriptor, offer buffer, write status back.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_OFFER = 2'd2,
        SQ_WBACK = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rxp_arm_reg.sv
// Arm flag behind the command register.
// Any write sets it and a not-empty descriptor clears it. A low enable forces
// it clear and wins over both. Assumes the write strobe lasts one cycle per write.
module rxp_arm_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic eth_en,
    input  logic wr,
    input  logic hw_clr,
    output logic active
);
    // Arm flag update: enable low > software write > hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (!eth_en) active <= 1'b0;
        else if (wr)      active <= 1'b1;
        else if (hw_clr)  active <= 1'b0;
    end

    // R1
    wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && eth_en) |=> active);
    // R5
    en_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eth_en |=> !active);
    // R4
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && !wr && eth_en) |=> !active);
endmodule

// File: rtl/rxp_ring_ptr.sv
// Ring pointer register.
// On each advance it either steps by one descriptor or returns to the ring base
// when the wrap flag is set. It is held at the base while the enable is low.
// Assumes the base stays constant while polling is enabled.
module rxp_ring_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eth_en,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    // Pointer update: rewind on reset or disable, wrap or step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !eth_en) ptr <= base;
        else if (adv)          ptr <= wrap ? base : ptr + STEP;
    end

    // R7
    wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eth_en && adv && wrap) |=> (ptr == $past(base)));
    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eth_en && adv && !wrap) |=> (ptr == $past(ptr) + STEP));
    // R9
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eth_en |=> (ptr == $past(base)));
endmodule

// File: rtl/rxp_seq.sv
// Poll sequencer.
// It fetches one descriptor, then offers an empty one to the datapath, writes the
// cleared status back and asks the pointer to advance. A not-empty descriptor
// raises a hardware clear and the sequencer goes idle. Assumes the acknowledges
// arrive only while the matching request is high.
module rxp_seq
    import rxp_pkg::*;
#(
    parameter int SW        = 16,
    parameter int EMPTY_BIT = 15,
    parameter int WRAP_BIT  = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eth_en,
    input  logic          active,
    input  logic          desc_ack,
    input  logic [SW-1:0] desc_status,
    input  logic          rx_done,
    input  logic          wb_ack,
    output logic          desc_req,
    output logic          rx_buf_valid,
    output logic          wb_req,
    output logic [SW-1:0] wb_data,
    output logic          hw_clr,
    output logic          adv,
    output logic          wrap
);
    localparam logic [SW-1:0] EMPTY_MASK = SW'(1) << EMPTY_BIT;

    seq_state_e    state_q, state_d;
    logic [SW-1:0] held_q;

    // Next-state decode for the fetch/offer/write-back cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (active) state_d = SQ_FETCH;
            SQ_FETCH: if (desc_ack)
                          state_d = desc_status[EMPTY_BIT] ? SQ_OFFER : SQ_IDLE;
            SQ_OFFER: if (rx_done) state_d = SQ_WBACK;
            SQ_WBACK: if (wb_ack)  state_d = SQ_FETCH;
            default:               state_d = SQ_IDLE;
        endcase
        if (!eth_en) state_d = SQ_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Capture the fetched status word for the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                              held_q <= '0;
        else if (state_q == SQ_FETCH && desc_ack) held_q <= desc_status;
    end

    assign desc_req     = (state_q == SQ_FETCH);
    assign rx_buf_valid = (state_q == SQ_OFFER);
    assign wb_req       = (state_q == SQ_WBACK);
    assign wb_data      = held_q & ~EMPTY_MASK;
    assign hw_clr       = desc_req && desc_ack && !desc_status[EMPTY_BIT];
    assign adv          = wb_req && wb_ack;
    assign wrap         = held_q[WRAP_BIT];

    // R10
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_req, rx_buf_valid, wb_req}));
    // R6
    offer_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && desc_ack && desc_status[EMPTY_BIT] && eth_en) |=> rx_buf_valid);
    // R6
    wb_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf_valid && rx_done && eth_en) |=> wb_req);
endmodule

// File: rtl/rx_ring_poller.sv
// Top level of the receive descriptor ring poll controller.
// It joins the arm register, the ring pointer and the poll sequencer, and forms
// the 32-bit command readback. Assumes one outstanding access on each memory port.
module rx_ring_poller #(
    parameter int AW         = 32,
    parameter int SW         = 16,
    parameter int DESC_BYTES = 8,
    parameter int EMPTY_BIT  = 15,
    parameter int WRAP_BIT   = 13,
    parameter int ARM_BIT    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eth_en,
    input  logic [AW-1:0] ring_base,
    input  logic          cmd_wr,
    input  logic [31:0]   cmd_wdata,
    output logic [31:0]   cmd_rdata,
    output logic          desc_req,
    output logic [AW-1:0] desc_addr,
    input  logic          desc_ack,
    input  logic [SW-1:0] desc_status,
    output logic          rx_buf_valid,
    output logic [AW-1:0] rx_buf_addr,
    input  logic          rx_done,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    output logic [SW-1:0] wb_data,
    input  logic          wb_ack
);
    logic          active;
    logic          hw_clr;
    logic          adv;
    logic          wrap;
    logic [AW-1:0] ptr;
    logic          unused_wdata;

    assign unused_wdata = ^cmd_wdata;

    rxp_arm_reg u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .eth_en (eth_en),
        .wr     (cmd_wr),
        .hw_clr (hw_clr),
        .active (active)
    );

    rxp_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .eth_en (eth_en),
        .base   (ring_base),
        .adv    (adv),
        .wrap   (wrap),
        .ptr    (ptr)
    );

    rxp_seq #(.SW(SW), .EMPTY_BIT(EMPTY_BIT), .WRAP_BIT(WRAP_BIT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .eth_en       (eth_en),
        .active       (active),
        .desc_ack     (desc_ack),
        .desc_status  (desc_status),
        .rx_done      (rx_done),
        .wb_ack       (wb_ack),
        .desc_req     (desc_req),
        .rx_buf_valid (rx_buf_valid),
        .wb_req       (wb_req),
        .wb_data      (wb_data),
        .hw_clr       (hw_clr),
        .adv          (adv),
        .wrap         (wrap)
    );

    // Readback: only the arm flag is visible.
    always_comb begin
        cmd_rdata          = '0;
        cmd_rdata[ARM_BIT] = active;
    end

    assign desc_addr   = ptr;
    assign rx_buf_addr = ptr;
    assign wb_addr     = ptr;

    // R3
    idle_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(desc_req || rx_buf_valid || wb_req));
    // R3
    fetch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> (active && $past(eth_en)));
    // R8
    collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && cmd_wr && eth_en) |=> active);
endmodule

// File: tb/tb_rx_ring_poller.sv
// Scoreboard bench.
// A memory model answers fetches and write-backs. Expected write-backs are queued
// by the test sequence and compared by the monitor as the design issues them.
module tb_rx_ring_poller;
    localparam int AW = 16;
    localparam int SW = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;
    localparam logic [31:0] ARMED = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eth_en = 1'b0;
    logic cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic desc_req, rx_buf_valid, wb_req;
    logic [AW-1:0] desc_addr, rx_buf_addr, wb_addr;
    logic [SW-1:0] wb_data;
    logic desc_ack = 1'b0, rx_done = 1'b0, wb_ack = 1'b0;
    logic [SW-1:0] desc_status = '0;

    logic [SW-1:0] mem [8];
    logic [AW+SW-1:0] exp_q [$];
    int n_chk = 0, n_fail = 0;
    int fetch_cnt = 0;
    logic [AW-1:0] last_fetch = '0;
    logic hold_rx = 1'b0, collide = 1'b0, collided = 1'b0;

    always #2.5 clk = ~clk;

    rx_ring_poller #(.AW(AW), .SW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .eth_en(eth_en), .ring_base(BASE),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
        .desc_status(desc_status), .rx_buf_valid(rx_buf_valid),
        .rx_buf_addr(rx_buf_addr), .rx_done(rx_done), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one command write, then sample the readback one cycle later.
    task automatic wr_cmd(input logic [31:0] d);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = d;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic expect_wb(input logic [AW-1:0] a, input logic [SW-1:0] s);
        exp_q.push_back({a, s});
    endtask

    task automatic wait_disarm();
        for (int i = 0; i < 200 && cmd_rdata[24]; i++) @(negedge clk);
    endtask

    // Memory model responder and write-back monitor.
    always @(negedge clk) begin
        if (collided) begin cmd_wr <= 1'b0; collided <= 1'b0; end
        if (desc_req && !desc_ack) begin
            desc_ack    <= 1'b1;
            desc_status <= mem[desc_addr[5:3]];
            last_fetch  <= desc_addr;
            fetch_cnt   <= fetch_cnt + 1;
            if (collide && !mem[desc_addr[5:3]][15]) begin
                cmd_wr <= 1'b1; collide <= 1'b0; collided <= 1'b1;
            end
        end else desc_ack <= 1'b0;
        rx_done <= rx_buf_valid && !rx_done && !hold_rx;
        if (wb_req && !wb_ack) begin
            wb_ack <= 1'b1;
            mem[wb_addr[5:3]] <= wb_data;
            if (exp_q.size() == 0) check(0, "R6 unexpected write-back", {16'h0, wb_addr}, 0);
            else begin
                logic [AW+SW-1:0] e;
                e = exp_q.pop_front();
                check({wb_addr, wb_data} == e, "R6 write-back addr/status",
                      {wb_addr, wb_data}, e);
            end
        end else wb_ack <= 1'b0;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int fc;
        logic seen;
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_rdata == 0, "R5 reset readback", cmd_rdata, 0);
        check(!desc_req && !rx_buf_valid && !wb_req, "R3 idle after reset",
              {desc_req, rx_buf_valid, wb_req}, 0);
        eth_en = 1'b1;

        // Three empty descriptors, then a not-empty one.
        mem[0] = 16'h8000; mem[1] = 16'h8001; mem[2] = 16'h8002; mem[3] = 16'h0003;
        expect_wb(BASE, 16'h0000); expect_wb(BASE + 8, 16'h0001);
        expect_wb(BASE + 16, 16'h0002);
        wr_cmd(32'h0);
        check(cmd_rdata == ARMED, "R1 R2 armed by zero data", cmd_rdata, ARMED);
        wait_disarm();
        check(cmd_rdata == 0, "R4 disarm on not-empty", cmd_rdata, 0);
        check(fetch_cnt == 4, "R4 fetch count", fetch_cnt, 4);
        check(last_fetch == BASE + 24, "R7 step by 8", {16'h0, last_fetch}, {16'h0, BASE + 16'd24});
        seen = 1'b0;
        repeat (10) begin @(negedge clk); seen |= desc_req; end
        check(!seen, "R4 no polling until next write", seen, 0);
        check(exp_q.size() == 0, "R6 all write-backs seen", exp_q.size(), 0);

        // Wrap on the fourth descriptor back to an already-used one.
        mem[3] = 16'hA003;
        expect_wb(BASE + 24, 16'h2003);
        fc = fetch_cnt;
        wr_cmd(32'hFFFF_FFFF);
        check(cmd_rdata == ARMED, "R1 R2 data ignored", cmd_rdata, ARMED);
        wait_disarm();
        check(last_fetch == BASE, "R7 wrap to base", {16'h0, last_fetch}, {16'h0, BASE});
        check(fetch_cnt == fc + 2, "R7 fetches around wrap", fetch_cnt, fc + 2);
        check(exp_q.size() == 0, "R6 wrap write-back seen", exp_q.size(), 0);

        // Command write colliding with a not-empty fetch.
        fc = fetch_cnt;
        collide = 1'b1;
        wr_cmd(32'h1234_5678);
        wait (collided == 1'b1);
        @(negedge clk);
        check(cmd_rdata == ARMED, "R8 write wins over clear", cmd_rdata, ARMED);
        wait_disarm();
        check(fetch_cnt == fc + 2, "R8 re-fetch after collision", fetch_cnt, fc + 2);

        // Enable drop while a buffer is offered mid-ring.
        mem[0] = 16'h8010; mem[1] = 16'h8011;
        expect_wb(BASE, 16'h0010);
        hold_rx = 1'b0;
        wr_cmd(32'h0);
        wait (wb_req == 1'b1);
        hold_rx = 1'b1;
        wait (rx_buf_valid == 1'b1);
        @(negedge clk);
        check(rx_buf_addr == BASE + 8, "R6 offer address", {16'h0, rx_buf_addr}, {16'h0, BASE + 16'd8});
        check(!desc_req && !wb_req, "R10 offer exclusive", {desc_req, wb_req}, 0);
        eth_en = 1'b0;
        @(negedge clk);
        check(cmd_rdata == 0, "R5 enable low disarms", cmd_rdata, 0);
        check(!rx_buf_valid, "R5 offer withdrawn", rx_buf_valid, 0);
        wr_cmd(32'h1);
        check(cmd_rdata == 0, "R5 write ignored while disabled", cmd_rdata, 0);
        seen = 1'b0;
        repeat (5) begin @(negedge clk); seen |= desc_req; end
        check(!seen, "R3 no fetch while disabled", seen, 0);

        // Re-enable: polling restarts at the base.
        hold_rx = 1'b0;
        mem[0] = 16'h0000;
        eth_en = 1'b1;
        fc = fetch_cnt;
        wr_cmd(32'h0);
        wait_disarm();
        check(last_fetch == BASE, "R9 restart at base", {16'h0, last_fetch}, {16'h0, BASE});
        check(fetch_cnt == fc + 1, "R9 single fetch", fetch_cnt, fc + 1);
        check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule